// File: doc/BRIEF.md
# TMDS Lane Receiver and Character Decoder

This block takes one TMDS data lane as a serial stream, one bit per clock in a single clock domain. It rebuilds 10-bit characters, where the bit that arrives first becomes bit 0. It searches for the character boundary on its own. While it has no lock, it watches for the four high-transition control tokens that a transmitter sends on every blanking pixel. If none appears for a long stretch, it moves its boundary one bit later. Once a steady run of tokens appears at one phase, it declares lock.

While locked, it presents one result per character. A control token gives data-enable low and the two control bits. Any other character gives data-enable high and the 8-bit pixel value. To recover the pixel value, it undoes the optional complement and then the XOR/XNOR transition-minimizing chain. A non-token character that sits alone inside a run of tokens counts as a corrupted symbol. The block reports each such symbol with a one-cycle strobe. Too many of them within one line cause it to give up lock and search again.

The output is a stream without back-pressure. A serial link cannot be paused, so there is no ready input. Whenever `out_valid` is high, the consumer must take the character in that same cycle. Lock and the error strobe are plain status pins.

Top module: `tmds_lane_rx`

## Requirements
- R1: Characters are 10 bits, and the first serial bit received becomes bit 0. Each result appears with `out_valid` high on the clock edge after the edge that samples the character's last bit. `out_valid` is never high on two consecutive cycles.
- R2: The four control tokens are, written bit 9 down to bit 0: 1101010100 for control 00, 0010101011 for 01, 0101010100 for 10, and 1010101011 for 11. When a token is decoded, `out_de` is 0, `out_ctl` carries the control value (bit 1 = C1, bit 0 = C0) and `out_data` is 0.
- R3: Any other character gives `out_de` = 1 and `out_ctl` = 00. When bit 9 is set, bits 7:0 are complemented first; call the result q. The data is D0 = q0 and Di = qi ^ qi-1 for i = 1 to 7. When bit 8 is 0, D1 to D7 are also inverted.
- R4: During and right after reset, `locked`, `out_valid` and `sym_err` are 0.
- R5: Lock is set on the decode of the 8th consecutive control token at the current phase. `out_valid` is high only for characters decoded while already locked, so the first result is the character after that 8th token.
- R6: While unlocked, 32 consecutive non-token characters move the boundary one bit later. Repeating this steps through all 10 phases, so lock is reached from any starting offset.
- R7: While locked, a non-token character that comes after a token and before another token raises `sym_err` for one cycle. The strobe comes with the decode of the following token.
- R8: The 4th such error drops `locked` on the edge that raises its strobe. The error count clears when two non-token characters follow a token, which marks the start of an active line. Fewer than 4 errors between such starts leave lock in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; all logic on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial lane bit, one per clock |
| out_valid | output | 1 | One-cycle strobe per decoded character while locked |
| out_data | output | 8 | Recovered pixel value (0 for tokens) |
| out_de | output | 1 | 1 for pixel data, 0 for a control token |
| out_ctl | output | 2 | Control bits {C1,C0} of a token (0 for data) |
| locked | output | 1 | Character boundary acquired |
| sym_err | output | 1 | One-cycle strobe for a corrupted symbol in blanking |

## Verification
Three results are due on the edge after the edge that samples a character's final bit: the decoded result, the lock change and the error strobe. That edge also stores the character. The bench drives bits on falling edges and tags each character it sends. It keeps a two-stage pipeline of expected results and compares the outputs two falling edges after the last bit of each character. This lets it tell which character set or dropped lock and which token carried the error strobe. It also checks that no result appears anywhere else.

// File: rtl/tmds_rx_pkg.sv
package tmds_rx_pkg;
  localparam int SYM_W  = 10;
  localparam int DATA_W = 8;

  // Blanking tokens, bit 9 down to bit 0, indexed by {C1,C0}
  localparam logic [SYM_W-1:0] TOK_C00 = 10'b1101010100;
  localparam logic [SYM_W-1:0] TOK_C01 = 10'b0010101011;
  localparam logic [SYM_W-1:0] TOK_C10 = 10'b0101010100;
  localparam logic [SYM_W-1:0] TOK_C11 = 10'b1010101011;

  typedef struct packed {
    logic       hit;
    logic [1:0] ctl;
  } tok_match_t;

  function automatic tok_match_t tok_lookup(input logic [SYM_W-1:0] w);
    tok_match_t m;
    m.hit = 1'b1;
    m.ctl = 2'b00;
    case (w)
      TOK_C00: m.ctl = 2'b00;
      TOK_C01: m.ctl = 2'b01;
      TOK_C10: m.ctl = 2'b10;
      TOK_C11: m.ctl = 2'b11;
      default: m.hit = 1'b0;
    endcase
    return m;
  endfunction

  // Undo conditional complement, then the XOR / XNOR chain
  function automatic logic [DATA_W-1:0] pix_recover(input logic [SYM_W-1:0] w);
    logic [DATA_W-1:0] q;
    logic [DATA_W-1:0] d;
    q    = w[9] ? ~w[DATA_W-1:0] : w[DATA_W-1:0];
    d[0] = q[0];
    for (int i = 1; i < DATA_W; i++) begin
      d[i] = q[i] ^ q[i-1] ^ ~w[8];
    end
    return d;
  endfunction
endpackage

// File: rtl/tmds_rx_deser.sv
module tmds_rx_deser
  import tmds_rx_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ser_in,
  input  logic             slip,
  output logic [SYM_W-1:0] word,
  output logic             word_vld
);
  localparam int CW = $clog2(SYM_W);

  logic [CW-1:0]    phase;
  logic [SYM_W-1:0] shreg;
  logic [SYM_W-1:0] next_shreg;

  // newest bit enters at the top, so the oldest ends at bit 0
  assign next_shreg = {ser_in, shreg[SYM_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= '0;
      shreg    <= '0;
      word     <= '0;
      word_vld <= 1'b0;
    end else begin
      shreg    <= next_shreg;
      word_vld <= 1'b0;
      if (slip) begin
        phase <= phase;            // stretch this character by one bit
      end else if (phase == CW'(SYM_W - 1)) begin
        phase    <= '0;
        word     <= next_shreg;
        word_vld <= 1'b1;
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end

  assert_word_gap_R1: assert property (@(posedge clk) disable iff (rst)
    word_vld |=> !word_vld);
endmodule

// File: rtl/tmds_rx_align.sv
module tmds_rx_align #(
  parameter int LOCK_RUN   = 8,
  parameter int MISS_LIMIT = 32,
  parameter int ERR_LIMIT  = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic word_vld,
  input  logic is_tok,
  output logic locked,
  output logic slip,
  output logic sym_err
);
  localparam int RW = $clog2(LOCK_RUN + 1);
  localparam int MW = $clog2(MISS_LIMIT + 1);
  localparam int EW = $clog2(ERR_LIMIT + 1);

  logic [RW-1:0] run_cnt;
  logic [MW-1:0] miss_cnt;
  logic [EW-1:0] err_cnt;
  logic          prev1_tok;
  logic          prev2_tok;
  logic          glitch;
  logic          line_go;

  // judged one character late: token, lone non-token, token
  assign glitch  = is_tok && !prev1_tok && prev2_tok;
  // token followed by two non-tokens: active line has begun
  assign line_go = !is_tok && !prev1_tok && prev2_tok;

  always_ff @(posedge clk) begin
    if (rst) begin
      locked    <= 1'b0;
      slip      <= 1'b0;
      sym_err   <= 1'b0;
      run_cnt   <= '0;
      miss_cnt  <= '0;
      err_cnt   <= '0;
      prev1_tok <= 1'b0;
      prev2_tok <= 1'b0;
    end else begin
      slip    <= 1'b0;
      sym_err <= 1'b0;
      if (word_vld) begin
        prev1_tok <= is_tok;
        prev2_tok <= prev1_tok;
        if (!locked) begin
          if (is_tok) begin
            miss_cnt <= '0;
            if (run_cnt == RW'(LOCK_RUN - 1)) begin
              locked  <= 1'b1;
              run_cnt <= '0;
              err_cnt <= '0;
            end else begin
              run_cnt <= run_cnt + 1'b1;
            end
          end else begin
            run_cnt <= '0;
            if (miss_cnt == MW'(MISS_LIMIT - 1)) begin
              miss_cnt <= '0;
              slip     <= 1'b1;
            end else begin
              miss_cnt <= miss_cnt + 1'b1;
            end
          end
        end else if (glitch) begin
          sym_err <= 1'b1;
          if (err_cnt == EW'(ERR_LIMIT - 1)) begin
            locked   <= 1'b0;
            err_cnt  <= '0;
            run_cnt  <= '0;
            miss_cnt <= '0;
          end else begin
            err_cnt <= err_cnt + 1'b1;
          end
        end else if (line_go) begin
          err_cnt <= '0;
        end
      end
    end
  end

  assert_slip_unlocked_R6: assert property (@(posedge clk) disable iff (rst)
    slip |-> !locked);
  assert_lock_on_token_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(word_vld && is_tok));
  assert_err_when_locked_R7: assert property (@(posedge clk) disable iff (rst)
    sym_err |-> $past(locked));
  assert_err_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    sym_err |=> !sym_err);
endmodule

// File: rtl/tmds_rx_decode.sv
module tmds_rx_decode
  import tmds_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [SYM_W-1:0]  word,
  input  logic              word_vld,
  input  logic              locked,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_de,
  output logic [1:0]        out_ctl
);
  tok_match_t tm;
  assign tm = tok_lookup(word);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_de    <= 1'b0;
      out_ctl   <= 2'b00;
    end else begin
      out_valid <= word_vld && locked;
      if (word_vld) begin
        if (tm.hit) begin
          out_de   <= 1'b0;
          out_ctl  <= tm.ctl;
          out_data <= '0;
        end else begin
          out_de   <= 1'b1;
          out_ctl  <= 2'b00;
          out_data <= pix_recover(word);
        end
      end
    end
  end

  assert_valid_needs_lock_R5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(locked));
  assert_token_zero_data_R2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_de) |-> (out_data == '0));
  assert_no_back_to_back_R1: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);
endmodule

// File: rtl/tmds_lane_rx.sv
module tmds_lane_rx
  import tmds_rx_pkg::*;
#(
  parameter int LOCK_RUN   = 8,
  parameter int MISS_LIMIT = 32,
  parameter int ERR_LIMIT  = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ser_in,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_de,
  output logic [1:0] out_ctl,
  output logic       locked,
  output logic       sym_err
);
  logic [SYM_W-1:0] word;
  logic             word_vld;
  logic             slip;
  tok_match_t       tm;

  assign tm = tok_lookup(word);

  tmds_rx_deser u_deser (
    .clk      (clk),
    .rst      (rst),
    .ser_in   (ser_in),
    .slip     (slip),
    .word     (word),
    .word_vld (word_vld)
  );

  tmds_rx_align #(
    .LOCK_RUN   (LOCK_RUN),
    .MISS_LIMIT (MISS_LIMIT),
    .ERR_LIMIT  (ERR_LIMIT)
  ) u_align (
    .clk      (clk),
    .rst      (rst),
    .word_vld (word_vld),
    .is_tok   (tm.hit),
    .locked   (locked),
    .slip     (slip),
    .sym_err  (sym_err)
  );

  tmds_rx_decode u_decode (
    .clk       (clk),
    .rst       (rst),
    .word      (word),
    .word_vld  (word_vld),
    .locked    (locked),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_de    (out_de),
    .out_ctl   (out_ctl)
  );

  assert_reset_quiet_R4: assert property (@(posedge clk)
    $past(rst) |-> (!locked && !out_valid && !sym_err));
endmodule

// File: tb/sim_tmds_lane_rx.sv
module sim_tmds_lane_rx;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ser_in = 1'b0;
  logic       out_valid;
  logic [7:0] out_data;
  logic       out_de;
  logic [1:0] out_ctl;
  logic       locked;
  logic       sym_err;

  always #5 clk = ~clk;

  tmds_lane_rx u0 (
    .clk(clk), .rst(rst), .ser_in(ser_in), .out_valid(out_valid),
    .out_data(out_data), .out_de(out_de), .out_ctl(out_ctl),
    .locked(locked), .sym_err(sym_err)
  );

  localparam logic [9:0] T00 = 10'b1101010100;
  localparam logic [9:0] T01 = 10'b0010101011;
  localparam logic [9:0] T10 = 10'b0101010100;
  localparam logic [9:0] T11 = 10'b1010101011;

  int n_tests = 0, n_fail = 0;
  int cyc = 0;

  // transmit queue
  logic [9:0] q_sym [0:255];
  logic       q_de  [0:255];
  logic [7:0] q_d   [0:255];
  logic [1:0] q_c   [0:255];
  int         q_tag [0:255];
  int wr = 0, rd = 0, skew_req = 0, skew_done = 0;

  // driver state and two-stage expectation pipeline
  logic [9:0] c_sym; logic c_de; logic [7:0] c_d; logic [1:0] c_c; int c_tag; int bp = 0;
  logic a_v = 0, a_de = 0, b_v = 0, b_de = 0, b_lk = 0;
  logic [7:0] a_d = 0, b_d = 0; logic [1:0] a_c = 0, b_c = 0;
  int a_tag = 0, b_tag = 0;

  int mon_bad = 0, out_seen = 0, err_seen = 0, err_marked = 0;
  int rises = 0, falls = 0, lock_tag = -1, drop_tag = -1, b2b = 0;
  logic prev_lk = 0, prev_ov = 0;

  always @(negedge clk) begin
    // compare against the character whose last bit went out two falling edges ago
    if (b_v && b_lk) begin
      if (!out_valid || out_de !== b_de ||
          (b_de  && (out_data !== b_d || out_ctl !== 2'b00)) ||
          (!b_de && (out_ctl !== b_c || out_data !== 8'h00))) begin
        mon_bad++;
        if (mon_bad < 6)
          $display("[TB] mismatch v=%0b de=%0b d=%h c=%0d exp de=%0b d=%h c=%0d",
                   out_valid, out_de, out_data, out_ctl, b_de, b_d, b_c);
      end
    end else if (out_valid) begin
      mon_bad++;
    end
    if (out_valid) out_seen++;
    if (out_valid && prev_ov) b2b++;
    if (sym_err) begin err_seen++; if (b_tag == 3) err_marked++; end
    if (locked && !prev_lk) begin rises++; lock_tag = b_tag; end
    if (!locked && prev_lk) begin falls++; drop_tag = b_tag; end
    prev_lk = locked;
    prev_ov = out_valid;
    b_v = a_v; b_de = a_de; b_d = a_d; b_c = a_c; b_tag = a_tag; b_lk = locked;
    a_v = 1'b0;
    if (skew_done < skew_req) begin
      ser_in = 1'b0;
      skew_done++;
    end else begin
      if (bp == 0) begin
        if (rd != wr) begin
          c_sym = q_sym[rd % 256]; c_de = q_de[rd % 256]; c_d = q_d[rd % 256];
          c_c = q_c[rd % 256]; c_tag = q_tag[rd % 256]; rd++;
        end else begin
          c_sym = T00; c_de = 1'b0; c_d = 8'h00; c_c = 2'b00; c_tag = 0;
        end
      end
      ser_in = c_sym[bp];
      if (bp == 9) begin
        a_v = 1'b1; a_de = c_de; a_d = c_d; a_c = c_c; a_tag = c_tag; bp = 0;
      end else begin
        bp++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("[TB] FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_tests++; n_fail++;
      $display("[TB] FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      report();
    end
  end

  function automatic logic [9:0] mk_sym(input logic [7:0] d, input bit xor_m, input bit inv);
    logic [7:0] q;
    q[0] = d[0];
    for (int i = 1; i < 8; i++) q[i] = d[i] ^ q[i-1] ^ ~xor_m;
    return {inv, xor_m, inv ? ~q : q};
  endfunction

  function automatic logic [7:0] safe(input logic [7:0] d);
    if (d == 8'h02 || d == 8'h03 || d == 8'hFC || d == 8'hFD) return d ^ 8'h10;
    return d;
  endfunction

  task automatic push_tok(input logic [1:0] c, input int tag);
    logic [9:0] s;
    s = (c == 2'b00) ? T00 : (c == 2'b01) ? T01 : (c == 2'b10) ? T10 : T11;
    q_sym[wr % 256] = s; q_de[wr % 256] = 1'b0; q_d[wr % 256] = 8'h00;
    q_c[wr % 256] = c; q_tag[wr % 256] = tag; wr++;
  endtask

  task automatic push_dat(input logic [7:0] d, input bit xor_m, input bit inv, input int tag);
    q_sym[wr % 256] = mk_sym(d, xor_m, inv); q_de[wr % 256] = 1'b1; q_d[wr % 256] = d;
    q_c[wr % 256] = 2'b00; q_tag[wr % 256] = tag; wr++;
  endtask

  task automatic flush;
    for (int i = 0; i < 4000 && rd != wr; i++) @(negedge clk);
    repeat (40) @(negedge clk);
  endtask

  task automatic acquire(input int skew, input string req);
    int bad0;
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    skew_req = skew_req + skew;
    bad0 = mon_bad;
    for (int i = 0; i < 6000 && !locked; i++) @(negedge clk);
    check(locked == 1'b1, req, locked, 1);
    flush();
    check(mon_bad == bad0, "R5 no output before lock", mon_bad - bad0, 0);
  endtask

  task automatic t_reset;
    repeat (4) @(negedge clk);
    check(locked == 1'b0, "R4 locked", locked, 0);
    check(out_valid == 1'b0, "R4 out_valid", out_valid, 0);
    check(sym_err == 1'b0, "R4 sym_err", sym_err, 0);
  endtask

  task automatic t_tokens;
    int bad0, seen0;
    bad0 = mon_bad; seen0 = out_seen;
    push_tok(2'b00, 0); push_tok(2'b01, 0); push_tok(2'b10, 0); push_tok(2'b11, 0);
    push_tok(2'b11, 0); push_tok(2'b10, 0);
    flush();
    check(mon_bad == bad0, "R2 token decode", mon_bad - bad0, 0);
    check(out_seen - seen0 >= 6, "R1 one result per character", out_seen - seen0, 6);
  endtask

  task automatic t_pixels;
    int bad0, err0;
    logic [7:0] vals [0:7];
    vals[0] = 8'h00; vals[1] = 8'hFF; vals[2] = 8'h5A; vals[3] = 8'hA5;
    vals[4] = 8'h81; vals[5] = 8'h3C; vals[6] = 8'h17; vals[7] = 8'hE2;
    bad0 = mon_bad; err0 = err_seen;
    push_tok(2'b00, 0);
    for (int m = 0; m < 4; m++)
      for (int k = 0; k < 8; k++)
        push_dat(safe(vals[k] + 8'(m * 37)), m[0], m[1], 0);
    push_tok(2'b00, 0);
    flush();
    check(mon_bad == bad0, "R3 pixel recovery all four chain modes", mon_bad - bad0, 0);
    check(mon_bad == bad0, "R1 bit order and one-edge latency", mon_bad - bad0, 0);
    check(err_seen == err0, "R7 active run raises no error", err_seen - err0, 0);
    check(b2b == 0, "R1 no back-to-back valid", b2b, 0);
  endtask

  task automatic t_drop_and_relock;
    int err0, fall0;
    err0 = err_seen; fall0 = falls;
    push_tok(2'b00, 0); push_tok(2'b00, 0);
    for (int k = 0; k < 4; k++) begin
      push_dat(8'h55, 1'b1, 1'b0, 0);
      push_tok(2'b01, (k == 3) ? 2 : 5);
    end
    push_dat(8'h44, 1'b1, 1'b0, 0);
    for (int k = 0; k < 7; k++) push_tok(2'b00, 0);
    push_dat(8'h44, 1'b1, 1'b0, 0);
    for (int k = 0; k < 7; k++) push_tok(2'b00, 0);
    push_tok(2'b00, 1);
    flush();
    check(err_seen - err0 == 4, "R7 one strobe per lone symbol", err_seen - err0, 4);
    check(falls - fall0 == 1, "R8 lock dropped once", falls - fall0, 1);
    check(drop_tag == 2, "R8 drop on fourth error", drop_tag, 2);
    check(lock_tag == 1, "R5 relock on eighth token", lock_tag, 1);
    check(locked == 1'b1, "R5 locked after run", locked, 1);
  endtask

  task automatic t_line_clear;
    int err0, mk0, fall0;
    err0 = err_seen; mk0 = err_marked; fall0 = falls;
    push_tok(2'b10, 0);
    for (int k = 0; k < 3; k++) begin push_dat(8'h66, 1'b0, 1'b1, 0); push_tok(2'b10, 3); end
    push_tok(2'b00, 0);
    for (int k = 0; k < 6; k++) push_dat(8'(k * 19 + 5), 1'b1, 1'b1, 0);
    push_tok(2'b00, 0); push_tok(2'b00, 0); push_tok(2'b00, 0);
    for (int k = 0; k < 3; k++) begin push_dat(8'h66, 1'b0, 1'b1, 0); push_tok(2'b11, 3); end
    push_tok(2'b00, 0);
    flush();
    check(err_marked - mk0 == 6, "R7 strobe with the following token", err_marked - mk0, 6);
    check(err_seen - err0 == 6, "R7 error count", err_seen - err0, 6);
    check(falls - fall0 == 0, "R8 line start clears error count", falls - fall0, 0);
    check(locked == 1'b1, "R8 still locked", locked, 1);
  endtask

  initial begin
    t_reset();
    acquire(3, "R6 acquire from offset 3");
    t_tokens();
    t_pixels();
    acquire(7, "R6 acquire from offset 7");
    t_drop_and_relock();
    acquire(0, "R6 acquire from offset 0");
    t_line_clear();
    report();
  end
endmodule